// File: doc/BRIEF.md
# Stack Offset Tracker for Instruction Decode

This block sits beside the instruction decoder. It keeps the pending change to the stack pointer as a signed running offset. Push, pop, call and return therefore need no micro-op of their own for stack-pointer arithmetic. Each stack memory access has the current offset folded into its displacement. The architectural stack pointer is brought up to date only when an instruction really consumes it.

When an instruction names the stack pointer explicitly and the offset is nonzero, the block asks for one synchronizing micro-op that adds the offset to the register. It holds the decoder for that cycle and clears the offset. The decoder then presents the same instruction again, and it proceeds unchanged. The same sync is forced when a further adjustment would push the offset outside its signed range.

Every accepted branch stores its post-instruction offset in a small checkpoint file indexed by branch tag. A misprediction recovery request reloads the offset from the entry for that tag.

Top module: `sp_delta_tracker`

## Requirements
- R1: After reset the offset is zero, every checkpoint entry is zero, `sync_req` and `stall` are low, and an instruction of class other (code 0) sees `mem_disp` = 0.
- R2: A push (class 1) or call (class 3) that is accepted lowers the offset by the operand size. Its `mem_disp` is the lowered value, so two 4-byte pushes from zero give -4 and then -8.
- R3: A pop (class 2) or return (class 4) that is accepted drives `mem_disp` with the offset before the adjustment, and then raises the offset by the operand size.
- R4: The size code maps as follows: 0 selects 2 bytes, 1 selects 4 bytes, and 2 or 3 select 8 bytes.
- R5: An explicit stack-pointer use (class 5) with a nonzero offset raises `sync_req` and `stall` in that cycle, with `sync_delta` equal to the offset. The offset is zero in the next cycle.
- R6: An explicit stack-pointer use with a zero offset raises neither `sync_req` nor `stall`.
- R7: A push, pop, call or return whose adjustment would leave the signed offset range instead raises `sync_req` and `stall`, with `sync_delta` equal to the current offset, and clears the offset. When the instruction is re-presented, it adjusts from zero.
- R8: An accepted instruction with `in_branch` high writes its post-instruction offset into checkpoint `in_tag`. `recover` reloads the offset from checkpoint `recover_tag` in the next cycle.
- R9: While `recover` is high, the presented instruction is ignored: there is no sync, no stall, no offset adjustment and no checkpoint write.
- R10: An instruction that is stalled for a sync neither adjusts the offset nor writes a checkpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_class | input | 3 | Instruction class: 0 other, 1 push, 2 pop, 3 call, 4 return, 5 explicit stack-pointer use |
| in_size | input | 2 | Operand size code |
| in_branch | input | 1 | Instruction is a branch needing a checkpoint |
| in_tag | input | TAG_W | Checkpoint tag of the branch |
| recover | input | 1 | Misprediction recovery request |
| recover_tag | input | TAG_W | Tag of the mispredicted branch |
| mem_disp | output | DELTA_W | Offset to fold into the stack access displacement |
| sync_req | output | 1 | Inject a sync micro-op |
| sync_delta | output | DELTA_W | Offset carried by the sync micro-op |
| stall | output | 1 | Hold the decoder this cycle |

## Verification
A recovery request and a sync demand can arrive in the same cycle. This happens when a branch misprediction lands while the decoder presents an explicit stack-pointer use and the offset is nonzero. The bench drives exactly that, with an offset that differs from the checkpoint. It judges the result by `sync_req` and `stall` staying low in that cycle and by the next class-other displacement equalling the checkpoint value. A second collision puts a branch on an instruction that overflows: the bench later recovers that tag and expects the value stored at reset.

// File: rtl/sp_delta_pkg.sv
package sp_delta_pkg;

   typedef enum logic [2:0] {
      CLS_OTHER = 3'd0,
      CLS_PUSH  = 3'd1,
      CLS_POP   = 3'd2,
      CLS_CALL  = 3'd3,
      CLS_RET   = 3'd4,
      CLS_SPUSE = 3'd5
   } op_class_e;

   // operand size code to byte count
   function automatic logic [3:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    size_bytes = 4'd2;
         2'd1:    size_bytes = 4'd4;
         default: size_bytes = 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/sp_delta_adjust.sv
module sp_delta_adjust
   import sp_delta_pkg::*;
#(
   parameter int DELTA_W = 8
) (
   input  logic [2:0]         cls,
   input  logic [1:0]         size_code,
   input  logic [DELTA_W-1:0] delta_q,
   output logic [DELTA_W-1:0] disp,
   output logic [DELTA_W-1:0] delta_nxt,
   output logic               adjusts,
   output logic               overflow
);
   localparam int EXT_W = DELTA_W + 1;

   logic [EXT_W-1:0] ext;
   logic [EXT_W-1:0] amt;
   logic [EXT_W-1:0] sum;

   always_comb begin
      ext     = {delta_q[DELTA_W-1], delta_q};
      amt     = EXT_W'(size_bytes(size_code));
      sum     = ext;
      disp    = delta_q;
      adjusts = 1'b0;
      case (op_class_e'(cls))
         CLS_PUSH, CLS_CALL: begin
            // push applies its offset before forming the address
            sum     = ext - amt;
            disp    = sum[DELTA_W-1:0];
            adjusts = 1'b1;
         end
         CLS_POP, CLS_RET: begin
            // pop forms its address first, then applies the offset
            sum     = ext + amt;
            disp    = delta_q;
            adjusts = 1'b1;
         end
         default: begin
            sum  = ext;
            disp = delta_q;
         end
      endcase
      overflow  = adjusts & (sum[EXT_W-1] ^ sum[DELTA_W-1]);
      delta_nxt = sum[DELTA_W-1:0];
   end

endmodule

// File: rtl/sp_delta_ckpt.sv
module sp_delta_ckpt #(
   parameter int DEPTH   = 8,
   parameter int DELTA_W = 8,
   localparam int TAG_W  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [DELTA_W-1:0] wr_data,
   input  logic [TAG_W-1:0]   rd_tag,
   output logic [DELTA_W-1:0] rd_data
);
   logic [DELTA_W-1:0] entry [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            entry[g] <= '0;
         end else if (wr_en && (wr_tag == TAG_W'(g))) begin
            entry[g] <= wr_data;
         end
      end
   end

   assign rd_data = entry[rd_tag];

   // a written entry reads back its data one cycle later
   assert_ckpt_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (entry[$past(wr_tag)] == $past(wr_data)));

endmodule

// File: rtl/sp_delta_tracker.sv
module sp_delta_tracker
   import sp_delta_pkg::*;
#(
   parameter int DELTA_W  = 8,
   parameter int NUM_CKPT = 8,
   localparam int TAG_W   = $clog2(NUM_CKPT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [2:0]         in_class,
   input  logic [1:0]         in_size,
   input  logic               in_branch,
   input  logic [TAG_W-1:0]   in_tag,
   input  logic               recover,
   input  logic [TAG_W-1:0]   recover_tag,
   output logic [DELTA_W-1:0] mem_disp,
   output logic               sync_req,
   output logic [DELTA_W-1:0] sync_delta,
   output logic               stall
);
   // elaboration checks
   if (DELTA_W < 5) begin : g_bad_width
      $error("DELTA_W must hold at least +/-8 with margin");
   end
   if (NUM_CKPT < 2 || (1 << TAG_W) != NUM_CKPT) begin : g_bad_depth
      $error("NUM_CKPT must be a power of two of at least 2");
   end

   logic [DELTA_W-1:0] delta_q;
   logic [DELTA_W-1:0] delta_d;
   logic [DELTA_W-1:0] delta_nxt;
   logic [DELTA_W-1:0] disp;
   logic [DELTA_W-1:0] ckpt_rd;
   logic               adjusts;
   logic               overflow;
   logic               is_spuse;
   logic               need_sync;
   logic               accept;

   sp_delta_adjust #(.DELTA_W(DELTA_W)) adj_i (
      .cls       (in_class),
      .size_code (in_size),
      .delta_q   (delta_q),
      .disp      (disp),
      .delta_nxt (delta_nxt),
      .adjusts   (adjusts),
      .overflow  (overflow)
   );

   sp_delta_ckpt #(.DEPTH(NUM_CKPT), .DELTA_W(DELTA_W)) ckpt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (accept && in_branch),
      .wr_tag  (in_tag),
      .wr_data (delta_nxt),
      .rd_tag  (recover_tag),
      .rd_data (ckpt_rd)
   );

   always_comb begin
      is_spuse  = in_valid && (op_class_e'(in_class) == CLS_SPUSE);
      need_sync = in_valid && !recover &&
                  ((is_spuse && (delta_q != '0)) || overflow);
      accept    = in_valid && !recover && !need_sync;
      if (recover)        delta_d = ckpt_rd;
      else if (need_sync) delta_d = '0;
      else if (accept)    delta_d = delta_nxt;
      else                delta_d = delta_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) delta_q <= '0;
      else        delta_q <= delta_d;
   end

   assign mem_disp   = disp;
   assign sync_req   = need_sync;
   assign sync_delta = need_sync ? delta_q : '0;
   assign stall      = need_sync;

   // a sync always carries a nonzero offset
   assert_sync_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req |-> (sync_delta != '0));

   // the offset is empty after a sync
   assert_sync_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_req && !recover) |=> (delta_q == '0));

   // recovery suppresses any sync
   assert_recover_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      recover |-> !sync_req && !stall);

   // recovery restores the checkpointed offset
   assert_recover_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      recover |=> (delta_q == $past(ckpt_rd)));

   // accepted push lowers the offset by the operand size
   assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !recover && !stall && op_class_e'(in_class) == CLS_PUSH)
      |=> (delta_q == $past(delta_q) - DELTA_W'(size_bytes($past(in_size)))));

   // accepted pop raises the offset by the operand size
   assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !recover && !stall && op_class_e'(in_class) == CLS_POP)
      |=> (delta_q == $past(delta_q) + DELTA_W'(size_bytes($past(in_size)))));

   // a stalled instruction leaves the offset at zero
   assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !recover) |=> (delta_q == '0));

endmodule

// File: tb/sp_delta_tracker_tb_top.sv
module sp_delta_tracker_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid;
   logic [2:0] in_class;
   logic [1:0] in_size;
   logic       in_branch;
   logic [2:0] in_tag;
   logic       recover;
   logic [2:0] recover_tag;
   logic [7:0] mem_disp;
   logic       sync_req;
   logic [7:0] sync_delta;
   logic       stall;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;  // 50 MHz

   sp_delta_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
      .in_size(in_size), .in_branch(in_branch), .in_tag(in_tag),
      .recover(recover), .recover_tag(recover_tag), .mem_disp(mem_disp),
      .sync_req(sync_req), .sync_delta(sync_delta), .stall(stall)
   );

   typedef struct packed {
      logic [2:0]        cls;
      logic [1:0]        sz;
      logic              br;
      logic [2:0]        tag;
      logic signed [7:0] disp;
      logic              sync;
      logic signed [7:0] sdelta;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TABLE [NV] = '{
      '{3'd1, 2'd1, 1'b0, 3'd0, -8'sd4,  1'b0, 8'sd0},  // R2 push 4
      '{3'd1, 2'd1, 1'b0, 3'd0, -8'sd8,  1'b0, 8'sd0},  // R2 push 4
      '{3'd2, 2'd0, 1'b0, 3'd0, -8'sd8,  1'b0, 8'sd0},  // R3 R4 pop 2
      '{3'd0, 2'd0, 1'b0, 3'd0, -8'sd6,  1'b0, 8'sd0},  // other
      '{3'd3, 2'd2, 1'b1, 3'd3, -8'sd14, 1'b0, 8'sd0},  // R8 call 8, ckpt 3
      '{3'd4, 2'd2, 1'b0, 3'd0, -8'sd14, 1'b0, 8'sd0},  // R3 ret 8
      '{3'd5, 2'd0, 1'b0, 3'd0, -8'sd6,  1'b1, -8'sd6}, // R5 sync
      '{3'd5, 2'd0, 1'b0, 3'd0, 8'sd0,   1'b0, 8'sd0},  // R6 no sync
      '{3'd1, 2'd3, 1'b0, 3'd0, -8'sd8,  1'b0, 8'sd0},  // R4 code 3 = 8
      '{3'd0, 2'd0, 1'b0, 3'd0, -8'sd8,  1'b0, 8'sd0}   // other
   };

   task automatic step(input logic [2:0] cls, input logic [1:0] sz,
                       input logic br, input logic [2:0] tag,
                       input logic rec, input logic [2:0] rtag,
                       input logic chk_disp, input logic [7:0] edisp,
                       input logic esync, input logic [7:0] esdelta,
                       input string req);
      @(negedge clk);
      in_valid = 1'b1; in_class = cls; in_size = sz; in_branch = br;
      in_tag = tag; recover = rec; recover_tag = rtag;
      #2;
      if (chk_disp) begin
         checks++;
         if (mem_disp !== edisp) begin
            errors++;
            $display("FAIL %s mem_disp actual %0d expected %0d", req,
                     $signed(mem_disp), $signed(edisp));
         end
      end
      checks++;
      if (sync_req !== esync || stall !== esync) begin
         errors++;
         $display("FAIL %s sync/stall actual %b/%b expected %b", req,
                  sync_req, stall, esync);
      end
      if (esync) begin
         checks++;
         if (sync_delta !== esdelta) begin
            errors++;
            $display("FAIL %s sync_delta actual %0d expected %0d", req,
                     $signed(sync_delta), $signed(esdelta));
         end
      end
      @(posedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; in_class = 3'd0; in_size = 2'd0;
      in_branch = 1'b0; in_tag = 3'd0; recover = 1'b0; recover_tag = 3'd0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R1 reset state
      step(3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 8'd0, 1'b0, 8'd0, "R1");

      for (int i = 0; i < NV; i++) begin
         step(TABLE[i].cls, TABLE[i].sz, TABLE[i].br, TABLE[i].tag, 1'b0, 3'd0,
              1'b1, TABLE[i].disp, TABLE[i].sync, TABLE[i].sdelta, "R2-R6 table");
      end

      // R8 recover to checkpoint 3 (-14)
      step(3'd0, 2'd0, 1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 8'd0, 1'b0, 8'd0, "R8");
      step(3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, -8'sd14, 1'b0, 8'd0, "R8");

      // R9 recovery collides with a sync demand
      step(3'd1, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, -8'sd16, 1'b0, 8'd0, "R2");
      step(3'd5, 2'd0, 1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 8'd0, 1'b0, 8'd0, "R9");
      step(3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, -8'sd14, 1'b0, 8'd0, "R9");

      // R1 checkpoints cleared by reset
      do_reset();
      step(3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 8'd0, 1'b0, 8'd0, "R1");
      step(3'd0, 2'd0, 1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 8'd0, 1'b0, 8'd0, "R1");
      step(3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 8'd0, 1'b0, 8'd0, "R1");

      // R7 push overflow after sixteen 8-byte pushes
      for (int i = 0; i < 16; i++) begin
         step(3'd1, 2'd2, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 8'((i + 1) * -8),
              1'b0, 8'd0, "R7 fill");
      end
      step(3'd1, 2'd2, 1'b1, 3'd6, 1'b0, 3'd0, 1'b0, 8'd0, 1'b1, -8'sd128,
           "R7 R10");
      step(3'd1, 2'd2, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, -8'sd8, 1'b0, 8'd0, "R7");
      // R10 stalled branch wrote no checkpoint
      step(3'd0, 2'd0, 1'b0, 3'd0, 1'b1, 3'd6, 1'b0, 8'd0, 1'b0, 8'd0, "R10");
      step(3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 8'd0, 1'b0, 8'd0, "R10");

      // R7 pop overflow
      for (int i = 0; i < 15; i++) begin
         step(3'd2, 2'd2, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 8'(i * 8),
              1'b0, 8'd0, "R7 pop fill");
      end
      step(3'd2, 2'd2, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 8'd0, 1'b1, 8'sd120, "R7");
      step(3'd2, 2'd2, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 8'd0, 1'b0, 8'd0, "R7 R3");
      step(3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 8'sd8, 1'b0, 8'd0, "R3");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule